// File: doc/BRIEF.md
# Clear-Only Programmable Memory with Pin-Mode Decode

This block is a synthesizable model of an 8192-word by 8-bit programmable read-only store. It is controlled through four pins rather than a write enable: an active-low chip select, an active-low output gate, an active-low program strobe and a flag that says the programming supply is present. These four inputs are decoded each cycle into standby, program-inhibit, output-off, read, verify or program. The decoded mode sets whether the store drives its data bus and whether a program strobe is accepted.

Programming can only clear bits. When the program strobe rises, the word at the sampled address becomes its old value ANDed with the sampled input data. The only way to return bits to one is a separate erase request. The erase walks through every location and writes all ones, with a busy flag raised for the whole walk. Read data is registered, and the output-drive flag stands in for a tristate bus: when it is low, the data bus reads zero.

Top module: `clrmem_core`

## Requirements
- R1: The store holds 8192 words of 8 bits, selected by a 13-bit address. After an erase completes, every word reads 8'hFF.
- R2: A committed program operation replaces the addressed word with (old word AND wr_data). A bit that reads 0 never returns to 1 through programming, even when wr_data is 8'hFF.
- R3: A program operation commits only in a cycle where pgm_n is sampled high after being sampled low in the previous cycle, and in that same cycle ce_n is low and hv_on is high. It uses the addr and wr_data sampled in that cycle. A strobe with ce_n high (inhibit) or with hv_on low leaves the store unchanged.
- R4: Read mode (ce_n=0, oe_n=0, pgm_n=1, hv_on=0) raises rd_drive and presents the addressed word on rd_data.
- R5: Verify mode (ce_n=0, oe_n=0, pgm_n=1, hv_on=1) raises rd_drive and presents the addressed word on rd_data.
- R6: Output-off mode (ce_n=0, oe_n=1) holds rd_drive low, whatever pgm_n and hv_on are.
- R7: With ce_n=1 (standby when hv_on=0, program-inhibit when hv_on=1), rd_drive is low, whatever oe_n and pgm_n are.
- R8: With ce_n=0, oe_n=0 and pgm_n=0, rd_drive is low. This covers program mode, and the same pins without hv_on.
- R9: rd_data is 8'h00 whenever rd_drive is low. After reset, rd_drive, rd_data and erase_busy are all low.
- R10: An erase_req pulse sampled while idle raises erase_busy from the next cycle for exactly 8192 cycles. Further erase_req pulses sampled while busy are ignored.
- R11: While erase_busy is high, rd_drive stays low one cycle later, and program strobes do not change the store.
- R12: rd_drive and rd_data reflect the pins and address sampled at the previous rising clock edge: one clock of latency, with no combinational path from input to output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| addr | input | 13 | Word address |
| wr_data | input | 8 | Data applied for a program operation |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low; commit on its rising edge |
| hv_on | input | 1 | Programming supply present |
| erase_req | input | 1 | Starts a full erase to all ones |
| rd_data | output | 8 | Registered read word, zero when not driving |
| rd_drive | output | 1 | Output-drive enable standing in for the tristate |
| erase_busy | output | 1 | Erase walk in progress |

## Verification
The assertions assume the pins are synchronous to clk and sampled only at its rising edge. A program strobe therefore has to last at least one full cycle low to be seen. The bench changes every input only on falling edges and holds each strobe low for a whole cycle, so each low phase and each rising edge of pgm_n is seen exactly once. Every program access in the bench keeps oe_n high, so no read of a word is ever made in the same cycle that the word is committed.

// File: rtl/clrmem_pkg.sv
package clrmem_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_INHIBIT = 3'd1,
    MODE_OUTOFF  = 3'd2,
    MODE_READ    = 3'd3,
    MODE_VERIFY  = 3'd4,
    MODE_PROGRAM = 3'd5
  } pin_mode_e;

  // Decode of the four control pins into one mode.
  function automatic pin_mode_e decode_pins(input logic ce_n, input logic oe_n,
                                            input logic pgm_n, input logic hv_on);
    pin_mode_e m;
    if (ce_n)                 m = hv_on ? MODE_INHIBIT : MODE_STANDBY;
    else if (hv_on && !pgm_n) m = MODE_PROGRAM;
    else if (oe_n)            m = MODE_OUTOFF;
    else if (!pgm_n)          m = MODE_OUTOFF;   // strobe low without supply
    else                      m = hv_on ? MODE_VERIFY : MODE_READ;
    return m;
  endfunction

  function automatic logic mode_drives(input pin_mode_e m);
    return (m == MODE_READ) || (m == MODE_VERIFY);
  endfunction

  // Clear-only merge: bits can fall to zero, never rise.
  function automatic logic [7:0] clear_merge(input logic [7:0] old_w,
                                             input logic [7:0] new_w);
    return old_w & new_w;
  endfunction

endpackage

// File: rtl/clrmem_decode.sv
module clrmem_decode
  import clrmem_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      hv_on,
  output pin_mode_e mode,
  output logic      drive_req,
  output logic      pgm_arm
);
  always_comb begin
    mode      = decode_pins(ce_n, oe_n, pgm_n, hv_on);
    drive_req = mode_drives(mode);
    // conditions checked at the rising edge of the strobe
    pgm_arm   = !ce_n && hv_on;
  end
endmodule

// File: rtl/clrmem_strobe.sv
module clrmem_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  output logic rise
);
  logic pgm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign rise = pgm_n && !pgm_q;
endmodule

// File: rtl/clrmem_eraser.sv
module clrmem_eraser #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else begin
      if (idx == LAST) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/clrmem_array.sv
module clrmem_array
  import clrmem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              clr_we,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [DATA_W-1:0] clr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_w;

  assign old_w = mem[clr_addr];

  always_ff @(posedge clk) begin
    if (fill_we)     mem[fill_addr] <= '1;
    else if (clr_we) mem[clr_addr]  <= DATA_W'(clear_merge(8'(old_w), 8'(clr_data)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else        rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/clrmem_core.sv
module clrmem_core
  import clrmem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              hv_on,
  input  logic              erase_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              erase_busy
);
  pin_mode_e         mode;
  logic              drive_req;
  logic              pgm_arm;
  logic              pgm_rise;
  logic              commit;
  logic [ADDR_W-1:0] erase_idx;
  logic [DATA_W-1:0] rd_word;
  logic              drive_q;

  clrmem_decode u_decode (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .hv_on(hv_on),
    .mode(mode), .drive_req(drive_req), .pgm_arm(pgm_arm)
  );

  clrmem_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .pgm_n(pgm_n), .rise(pgm_rise)
  );

  clrmem_eraser #(.ADDR_W(ADDR_W)) u_eraser (
    .clk(clk), .rst_n(rst_n), .start(erase_req),
    .busy(erase_busy), .idx(erase_idx)
  );

  // named event: program commit at the end of the strobe
  assign commit = pgm_rise && pgm_arm && !erase_busy;

  clrmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .fill_we(erase_busy), .fill_addr(erase_idx),
    .clr_we(commit), .clr_addr(addr), .clr_data(wr_data),
    .rd_addr(addr), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_req && !erase_busy && (mode != MODE_PROGRAM);
  end

  assign rd_drive = drive_q;
  assign rd_data  = drive_q ? rd_word : '0;
endmodule

// File: rtl/clrmem_chk.sv
module clrmem_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              hv_on,
  input logic              erase_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive,
  input logic              erase_busy,
  input logic              commit
);
  // R4
  drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> $past(!ce_n && !oe_n && pgm_n));

  // R7
  ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rd_drive);

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rd_data == '0));

  // R3
  commit_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (hv_on && !ce_n && $rose(pgm_n)));

  // R11
  busy_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !commit);

  // R11
  busy_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |=> !rd_drive);

  // R10
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> $past(erase_req));
endmodule

bind clrmem_core clrmem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
  .hv_on(hv_on), .erase_req(erase_req), .rd_data(rd_data),
  .rd_drive(rd_drive), .erase_busy(erase_busy), .commit(commit)
);

// File: tb/clrmem_core_tb.sv
module clrmem_core_tb;
  localparam int AW    = 13;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = 8'hFF;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, hv_on = 1'b0;
  logic          erase_req = 1'b0;
  logic [7:0]    rd_data;
  logic          rd_drive, erase_busy;

  logic [7:0] model [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clrmem_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .hv_on(hv_on),
    .erase_req(erase_req), .rd_data(rd_data), .rd_drive(rd_drive),
    .erase_busy(erase_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_a(input int a);
    return 8'(((a * 29) + (a >> 4)) ^ 8'hC3);
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 7) ^ (a >> 8) ^ 8'h96);
  endfunction

  // full pipelined read sweep, one address per cycle
  task automatic sweep(input string req, input logic hv);
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 1; hv_on = hv; addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check(req, {23'd0, rd_drive, rd_data}, {23'd0, 1'b1, model[i]});
      if (i < DEPTH - 1) addr = AW'(i + 1);
    end
  endtask

  // one program strobe: low for a cycle, rises at the next edge
  task automatic strobe(input int a, input logic [7:0] d, input logic ce, input logic hv);
    @(negedge clk);
    addr = AW'(a); wr_data = d; ce_n = ce; oe_n = 1; hv_on = hv; pgm_n = 0;
    @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
    if (!ce && hv) model[a] = model[a] & d;
  endtask

  task automatic read_one(input string req, input int a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 1; hv_on = 0; addr = AW'(a);
    @(negedge clk);
    check(req, {23'd0, rd_drive, rd_data}, {23'd0, 1'b1, model[a]});
  endtask

  task automatic erase_all(input bit probe);
    int cnt;
    @(negedge clk);
    ce_n = 1; oe_n = 1; pgm_n = 1; hv_on = 0; erase_req = 1;
    @(negedge clk);
    erase_req = 0;
    check("R10 busy after request", {31'd0, erase_busy}, 32'd1);
    cnt = 0;
    while (erase_busy && cnt < DEPTH + 16) begin
      cnt++;
      if (probe) begin
        if (cnt == 100) begin
          ce_n = 0; oe_n = 0; hv_on = 1; pgm_n = 0; addr = AW'(3); wr_data = 8'h00;
        end
        if (cnt == 101) pgm_n = 1;
        if (cnt == 102) begin
          check("R11 no drive while busy", {31'd0, rd_drive}, 32'd0);
          ce_n = 1; oe_n = 1; hv_on = 0;
        end
        if (cnt == 200) erase_req = 1;
        if (cnt == 201) erase_req = 0;
      end
      @(negedge clk);
    end
    check("R10 busy length", cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  initial begin
    // R9 reset state
    #12;
    check("R9 reset drive", {31'd0, rd_drive}, 32'd0);
    check("R9 reset data", {24'd0, rd_data}, 32'd0);
    check("R10 reset busy", {31'd0, erase_busy}, 32'd0);
    @(negedge clk); rst_n = 1;

    // R1 erase, then every word reads all ones
    erase_all(0);
    sweep("R1 erased read", 0);

    // R2 first pattern, checked through verify mode
    for (int i = 0; i < DEPTH; i++) strobe(i, pat_a(i), 0, 1);
    sweep("R5 verify pattern A", 1);

    // R2 second pattern: stored value is the AND of both
    for (int i = 0; i < DEPTH; i++) strobe(i, pat_b(i), 0, 1);
    sweep("R2 clear-only merge", 0);

    // R2 programming ones does not restore cleared bits
    strobe(10, 8'hFF, 0, 1);
    read_one("R2 ones ignored", 10);
    check("R2 model word", {24'd0, model[10]}, {24'd0, pat_a(10) & pat_b(10)});
    strobe(11, 8'h00, 0, 1);
    read_one("R2 clear to zero", 11);

    // R3 inhibit and no-supply strobes leave the store alone
    strobe(100, 8'h00, 1, 1);
    read_one("R3 inhibited strobe", 100);
    strobe(101, 8'h00, 0, 0);
    read_one("R3 strobe without supply", 101);
    // R3 strobe whose rising edge comes with ce_n high
    @(negedge clk);
    addr = AW'(102); wr_data = 8'h00; ce_n = 0; oe_n = 1; hv_on = 1; pgm_n = 0;
    @(negedge clk); ce_n = 1; pgm_n = 1;
    @(negedge clk);
    read_one("R3 rise sampled with ce_n high", 102);

    // R12 one clock of latency from address and select
    read_one("R12 setup", 200);
    addr = AW'(201);
    #1 check("R12 data held before edge", {24'd0, rd_data}, {24'd0, model[200]});
    @(negedge clk);
    check("R12 data after edge", {24'd0, rd_data}, {24'd0, model[201]});
    ce_n = 1;
    #1 check("R12 drive held before edge", {31'd0, rd_drive}, 32'd1);
    @(negedge clk);
    check("R7 drive off after edge", {31'd0, rd_drive}, 32'd0);

    // R4..R8 every pin combination; wr_data all ones keeps the store intact
    for (int c = 0; c < 16; c++) begin
      logic exp_d;
      string tag;
      @(negedge clk);
      {ce_n, oe_n, pgm_n, hv_on} = 4'(c); addr = AW'(77); wr_data = 8'hFF;
      @(negedge clk);
      exp_d = !c[3] && !c[2] && c[1];
      if (c[3])       tag = "R7 mode drive";
      else if (c[2])  tag = "R6 mode drive";
      else if (!c[1]) tag = "R8 mode drive";
      else if (c[0])  tag = "R5 mode drive";
      else            tag = "R4 mode drive";
      check(tag, {23'd0, rd_drive, rd_data}, {23'd0, exp_d, exp_d ? model[77] : 8'h00});
    end

    // R10 R11 erase with a strobe and a second request during the walk
    erase_all(1);
    @(negedge clk);
    check("R10 stays idle", {31'd0, erase_busy}, 32'd0);
    read_one("R11 strobe during erase ignored", 3);
    sweep("R1 erased again", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule